// File: doc/BRIEF.md
# Odd/Even Split Bus-Invert Codec

This block encodes words for a wide on-chip data bus so that neighbouring wires switch against each other less often. Two extra wires travel with the data. One of them says the odd-numbered data lines are inverted, and the other says the even-numbered lines are inverted. Together they give four ways to send each word: plain, odd half flipped, even half flipped, or everything flipped. For every accepted word the encoder scores all four candidates against the wires it drove last. The score counts coupling events between adjacent wires, and the invert wires count as wires too. The encoder then drives the cheapest candidate.

The two invert wires must never swap places in a single step, because that would be a strong opposite-phase event. When the best candidate would cause such a swap, the word is sent in two phases. The first phase drives the word uninverted with both invert wires low. The second phase drives the chosen candidate. The input side stalls for that extra cycle.

A decoder on the same block reads the driven wires and undoes the inversion. It presents the original word one cycle after the final phase of each transfer.

Top module: `oe_invert_codec`

## Requirements
- R1: After a synchronous active-high reset, `bus_data` is all zeros, both invert wires are 0, `bus_valid`, `bus_hold` and `out_valid` are 0, and `in_ready` is 1.
- R2: The mode is the pair {`bus_inv_odd`,`bus_inv_even`}: 00 means no lines inverted, 10 means the odd data lines (bit 1, 3, ...) are inverted, 01 means the even data lines (bit 0, 2, ...) are inverted, and 11 means every line is inverted. On a final phase, `bus_data` equals the word XOR the mask of that mode.
- R3: The wires are ordered even-invert, data bit 0 up to data bit 15, odd-invert. The cost of a candidate is summed over the 17 adjacent pairs of this order. A pair where exactly one wire toggles adds 1. A pair where both wires toggle in opposite directions adds 2. The encoder drives the candidate with the lowest cost against the previously driven wires.
- R4: When candidates have equal cost, the first one in the order 00, 01, 10, 11 is taken.
- R5: A word accepted at a clock edge (`in_valid` and `in_ready` both high) appears on the bus at that same edge with `bus_valid` high. If no two-phase transfer is needed, `bus_hold` is low.
- R6: The mode never changes from 01 to 10 or from 10 to 01 between consecutive cycles. When the chosen mode would do so, the first phase drives the raw word with mode 00 and `bus_hold` high, and `in_ready` is low during that cycle.
- R7: The cycle after a first phase drives the chosen mode with its data and `bus_hold` low. Any input presented while `in_ready` is low is not taken.
- R8: In a cycle with no transfer, `bus_valid` is low and the data and invert wires keep their values.
- R9: `out_valid` pulses one cycle after each final phase, and only then, with `out_data` equal to the original word. A first phase produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Source word offered |
| in_ready | output | 1 | Encoder can take a word this cycle |
| in_data | input | 16 | Source word |
| bus_data | output | 16 | Encoded data wires |
| bus_inv_odd | output | 1 | Odd data lines are inverted |
| bus_inv_even | output | 1 | Even data lines are inverted |
| bus_valid | output | 1 | A phase is driven this cycle |
| bus_hold | output | 1 | The driven phase is the first of two |
| out_valid | output | 1 | Decoded word present |
| out_data | output | 16 | Decoded word |

## Verification
The embedded properties check on every cycle that the invert wires never swap directly and that a first phase carries mode 00, stalls the input and is followed by a final phase. They also check that idle cycles leave the wires untouched and that decoded output follows only final phases. Whether the encoder really picked the cheapest candidate, and whether ties went the right way, can only be shown by the bench's reference model. That model rescores all four candidates over streams of alternating, sparse and random words, and the bench also checks the decoded word against the original.

// File: rtl/oe_invert_codec.sv
module oe_invert_codec #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] bus_data,
  output logic         bus_inv_odd,
  output logic         bus_inv_even,
  output logic         bus_valid,
  output logic         bus_hold,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int L  = W + 2;
  localparam int CW = $clog2(2 * (L - 1) + 1);

  logic [1:0]    bus_mode, pend_mode, best, mm;
  logic [W-1:0]  pend_data;
  logic [CW-1:0] best_cost, c;
  logic [L-1:0]  prev_w;
  logic          flip;

  function automatic logic [W-1:0] inv_mask(input logic [1:0] m);
    for (int i = 0; i < W; i++) inv_mask[i] = (i % 2 == 1) ? m[1] : m[0];
  endfunction

  function automatic logic [CW-1:0] couple_cost(input logic [L-1:0] a, input logic [L-1:0] b);
    logic ta, tb;
    couple_cost = '0;
    for (int i = 0; i < L - 1; i++) begin
      ta = a[i] ^ b[i];
      tb = a[i+1] ^ b[i+1];
      if (ta ^ tb) couple_cost = couple_cost + CW'(1);
      else if (ta && tb && (a[i] != a[i+1])) couple_cost = couple_cost + CW'(2);
    end
  endfunction

  assign prev_w       = {bus_mode[1], bus_data, bus_mode[0]};
  assign bus_inv_odd  = bus_mode[1];
  assign bus_inv_even = bus_mode[0];
  assign in_ready     = !bus_hold;

  always_comb begin
    best      = 2'b00;
    best_cost = couple_cost(prev_w, {1'b0, in_data, 1'b0});
    mm        = 2'b00;
    c         = best_cost;
    for (int m = 1; m < 4; m++) begin
      mm = 2'(m);
      c  = couple_cost(prev_w, {mm[1], in_data ^ inv_mask(mm), mm[0]});
      if (c < best_cost) begin
        best_cost = c;
        best      = mm;
      end
    end
  end

  assign flip = (bus_mode == 2'b01 && best == 2'b10) || (bus_mode == 2'b10 && best == 2'b01);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_data  <= '0;
      bus_mode  <= 2'b00;
      bus_valid <= 1'b0;
      bus_hold  <= 1'b0;
      pend_data <= '0;
      pend_mode <= 2'b00;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      bus_valid <= 1'b0;
      bus_hold  <= 1'b0;
      if (bus_hold) begin
        bus_data  <= pend_data ^ inv_mask(pend_mode);
        bus_mode  <= pend_mode;
        bus_valid <= 1'b1;
      end else if (in_valid) begin
        bus_valid <= 1'b1;
        if (flip) begin
          bus_data  <= in_data;
          bus_mode  <= 2'b00;
          bus_hold  <= 1'b1;
          pend_data <= in_data;
          pend_mode <= best;
        end else begin
          bus_data <= in_data ^ inv_mask(best);
          bus_mode <= best;
        end
      end
      out_valid <= bus_valid && !bus_hold;
      if (bus_valid) out_data <= bus_data ^ inv_mask(bus_mode);
    end
  end

  assert_no_direct_swap_R6: assert property (@(posedge clk) disable iff (rst)
    !(($past(bus_mode) == 2'b01 && bus_mode == 2'b10) || ($past(bus_mode) == 2'b10 && bus_mode == 2'b01)));

  assert_first_phase_plain_R6: assert property (@(posedge clk) disable iff (rst)
    bus_hold |-> (bus_mode == 2'b00 && bus_valid && !in_ready));

  assert_second_phase_follows_R7: assert property (@(posedge clk) disable iff (rst)
    bus_hold |=> (bus_valid && !bus_hold));

  assert_idle_keeps_wires_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> ($stable(bus_data) && $stable(bus_mode)));

  assert_output_after_final_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(bus_valid) && !$past(bus_hold)));

  assert_no_output_after_first_R9: assert property (@(posedge clk) disable iff (rst)
    $past(bus_hold) |-> !out_valid);
endmodule

// File: tb/sim_oe_invert_codec.sv
module sim_oe_invert_codec;
  logic clk = 0, rst = 1, in_valid = 0;
  logic [15:0] in_data = '0;
  logic in_ready, bus_inv_odd, bus_inv_even, bus_valid, bus_hold, out_valid;
  logic [15:0] bus_data, out_data;
  int checks = 0, errors = 0, holds = 0;
  bit cmp_on = 0, done = 0;

  oe_invert_codec u0 (.clk, .rst, .in_valid, .in_ready, .in_data, .bus_data, .bus_inv_odd,
    .bus_inv_even, .bus_valid, .bus_hold, .out_valid, .out_data);

  always #5 clk = ~clk;

  // Behavioural model state
  logic [15:0] m_bus, m_pword, m_oword;
  int m_mode, m_pmode;
  bit m_valid, m_hold, m_ovalid;

  function automatic logic [15:0] mmask(int m);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = (i % 2 == 1) ? (m >= 2) : (m % 2 == 1);
    return r;
  endfunction

  function automatic int mcost(logic [15:0] pd, int pm, logic [15:0] nd, int nm);
    int o[18], n[18], s, da, db;
    o[0] = pm % 2; o[17] = pm / 2; n[0] = nm % 2; n[17] = nm / 2;
    for (int i = 0; i < 16; i++) begin o[i+1] = int'(pd[i]); n[i+1] = int'(nd[i]); end
    s = 0;
    for (int k = 0; k < 17; k++) begin
      da = n[k] - o[k]; db = n[k+1] - o[k+1];
      if ((da != 0) != (db != 0)) s += 1;
      else if (da * db < 0) s += 2;
    end
    return s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_bus = '0; m_mode = 0; m_valid = 0; m_hold = 0; m_ovalid = 0; m_oword = '0;
      m_pword = '0; m_pmode = 0;
    end else begin
      int bm, bc, cc;
      m_ovalid = m_valid && !m_hold;
      if (m_ovalid) m_oword = m_pword;
      if (m_hold) begin
        m_hold = 0; m_valid = 1; m_mode = m_pmode; m_bus = m_pword ^ mmask(m_pmode);
      end else if (in_valid) begin
        bm = 0; bc = 1000;
        for (int m = 0; m < 4; m++) begin
          cc = mcost(m_bus, m_mode, in_data ^ mmask(m), m);
          if (cc < bc) begin bc = cc; bm = m; end
        end
        m_valid = 1; m_pword = in_data; m_pmode = bm;
        if ((m_mode == 1 && bm == 2) || (m_mode == 2 && bm == 1)) begin
          m_hold = 1; m_mode = 0; m_bus = in_data;
        end else begin
          m_mode = bm; m_bus = in_data ^ mmask(bm);
        end
      end else m_valid = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && !rst) begin
    chk("R2 R5 R8 bus_data", 32'(bus_data), 32'(m_bus));
    chk("R3 R4 mode", 32'({bus_inv_odd, bus_inv_even}), 32'(m_mode));
    chk("R5 R8 bus_valid", 32'(bus_valid), 32'(m_valid));
    chk("R6 bus_hold", 32'(bus_hold), 32'(m_hold));
    chk("R7 in_ready", 32'(in_ready), 32'(!m_hold));
    chk("R9 out_valid", 32'(out_valid), 32'(m_ovalid));
    if (m_ovalid) chk("R9 out_data", 32'(out_data), 32'(m_oword));
    if (bus_hold) holds++;
  end

  task automatic do_reset();
    rst = 1; in_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 bus_data", 32'(bus_data), 0);
    chk("R1 mode", 32'({bus_inv_odd, bus_inv_even}), 0);
    chk("R1 valid/hold/out", 32'({bus_valid, bus_hold, out_valid}), 0);
    chk("R1 in_ready", 32'(in_ready), 1);
    // R4 tie between 00 and 11 (cost 2 each) from reset
    in_valid = 1; in_data = 16'hFFFF;
    @(negedge clk); in_valid = 0;
    chk("R4 tie picks 00", 32'({bus_inv_odd, bus_inv_even}), 0);
    chk("R5 bus word", 32'(bus_data), 32'h0000FFFF);
    @(negedge clk);
    chk("R9 decoded", 32'(out_data), 32'h0000FFFF);
    chk("R8 idle holds", 32'({bus_valid, bus_data}), 32'h0000FFFF);
    // R3 and R4: 5555 from reset -> 01 and 10 tie at cost 1, 01 wins
    do_reset();
    in_valid = 1; in_data = 16'h5555;
    @(negedge clk); in_valid = 0;
    chk("R3 R4 mode 01", 32'({bus_inv_odd, bus_inv_even}), 1);
    chk("R2 even lines inverted", 32'(bus_data), 0);
    @(negedge clk);
    chk("R9 decoded 5555", 32'({out_valid, out_data}), 32'h00015555);
    // model-compared streams
    do_reset();
    cmp_on = 1;
    for (int n = 0; n < 4000; n++) begin
      in_valid = ($urandom_range(0, 3) != 0);
      case ((n / 500) % 4)
        0: in_data = ($urandom_range(0, 1) != 0) ? 16'h5555 : 16'hAAAA;
        1: in_data = 16'(1 << $urandom_range(0, 15)) ^ (($urandom_range(0, 1) != 0) ? 16'hAAAA : 16'h0000);
        2: in_data = 16'($urandom);
        default: in_data = ($urandom_range(0, 1) != 0) ? (16'h5555 ^ 16'(1 << $urandom_range(0, 15))) : 16'($urandom);
      endcase
      @(negedge clk);
    end
    in_valid = 0;
    repeat (3) @(negedge clk);
    cmp_on = 0;
    chk("R6 two-phase transfers seen", 32'(holds > 0), 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule